// File: doc/BRIEF.md
# Three-Bus Register Datapath with Memory Port

This block runs one datapath cycle for each control word it accepts. Each control word carries several settings:

- two source register selects, one for the A bus and one for the B bus;
- an ALU operation code;
- a destination register select;
- a 5-bit memory address and a memory direction flag;
- two switches: one closes the C bus and one closes the main memory bus.

The two selected registers drive the A and B buses. The ALU combines them into a C value. If the C bus is closed, that value goes to a register or, through the memory bus, straight into a memory word. A memory read over a closed memory bus sends the memory word down the C bus into a register.

Control words arrive on a valid/ready handshake. The block holds ready high only while it is idle, so the word is the only point of back-pressure. A word offered while ready is low waits and is not lost. The 32-word memory is slower than the register path, and every cycle that uses the memory bus stays busy for a fixed number of extra clocks.

When a cycle completes, a one-clock done pulse is raised and the C value of that cycle is presented. Setting the C bus switch open and selecting pass-A or a memory read lets a register or memory word be observed without changing anything. Instruction fetch and sequencing belong to the block that issues the control words.

Top module: `tribus_datapath`

## Requirements
- R1: `cw_ready` is high exactly when the block is idle. A control word is taken on a rising edge where `cw_valid` and `cw_ready` are both high, and `busy` is high with `cw_ready` low from that edge until the cycle completes.
- R2: A cycle that does not use the memory bus (`cw_m_en`=0) raises `done` one clock edge after acceptance. A cycle with `cw_m_en`=1 raises it MEM_LAT edges later than that (default 3). `done` is high for exactly one clock.
- R3: ALU codes on `cw_op` are 000 add, 001 subtract A−B, 010 AND, 011 OR, 100 XOR, 101 pass A, 110 pass the immediate `cw_imm`, and 111 zero. Add and subtract wrap modulo 2^16.
- R4: The A and B selects are independent, and the same register may feed both buses.
- R5: With `cw_c_en`=1 and `cw_m_en`=0, the ALU result is written to register `cw_c_sel`.
- R6: With `cw_c_en`=0, no register and no memory word changes, whatever the A, B, ALU, address and direction settings are.
- R7: With `cw_c_en`=1, `cw_m_en`=1 and `cw_mem_wr`=1, the ALU result is stored at memory word `cw_addr` and no register changes.
- R8: With `cw_c_en`=1, `cw_m_en`=1 and `cw_mem_wr`=0, memory word `cw_addr` is copied into register `cw_c_sel`. Addresses 0 to 31 are all reachable.
- R9: Reset clears all four registers, all 32 memory words, `done`, `busy` and `res_data`.
- R10: `res_data` takes the cycle's C value on the edge that raises `done` and holds it until the next completion. The C value is the memory word on a memory read (`cw_m_en`=1, `cw_mem_wr`=0) and the ALU result otherwise.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Asynchronous reset, active low |
| cw_valid | input | 1 | Control word offered |
| cw_ready | output | 1 | Block idle, control word will be taken |
| cw_a_sel | input | 2 | Register driving the A bus |
| cw_b_sel | input | 2 | Register driving the B bus |
| cw_op | input | 3 | ALU operation code |
| cw_imm | input | 16 | Immediate operand for code 110 |
| cw_c_sel | input | 2 | Destination register |
| cw_addr | input | 5 | Memory word address |
| cw_mem_wr | input | 1 | Memory direction: 1 write, 0 read |
| cw_c_en | input | 1 | C bus closed |
| cw_m_en | input | 1 | Memory bus closed |
| busy | output | 1 | Cycle in progress |
| done | output | 1 | One-clock completion pulse |
| res_data | output | 16 | C value of the last completed cycle |

## Verification
The bench drives subtraction with a larger B operand to force a wrap. A design that sign-extends or saturates would return the wrong value. It also selects the same register on both buses, where a design with coupled read ports would read a stale or wrong operand.

Control words with the C bus open mix every other setting, including memory writes. The affected registers and memory words are then read back, so a design that lets the ALU or the memory direction leak past an open C bus shows a changed word.

Memory reads and writes at addresses 0 and 31 expose address truncation. Completion latency is counted on every cycle, so a design that skips the memory wait, or pulses `done` for longer than one clock, is reported.

// File: rtl/tribus_pkg.sv
package tribus_pkg;

  // ALU operation codes carried on the op field of a control word
  localparam logic [2:0] OP_ADD  = 3'b000;
  localparam logic [2:0] OP_SUB  = 3'b001;
  localparam logic [2:0] OP_AND  = 3'b010;
  localparam logic [2:0] OP_OR   = 3'b011;
  localparam logic [2:0] OP_XOR  = 3'b100;
  localparam logic [2:0] OP_PASA = 3'b101;
  localparam logic [2:0] OP_IMM  = 3'b110;
  localparam logic [2:0] OP_ZERO = 3'b111;

  typedef enum logic [0:0] {
    ST_IDLE = 1'b0,
    ST_EXEC = 1'b1
  } dp_state_e;

endpackage

// File: rtl/tribus_alu.sv
module tribus_alu
  import tribus_pkg::*;
#(
  parameter int DW = 16
) (
  input  logic [2:0]    op,
  input  logic [DW-1:0] a,
  input  logic [DW-1:0] b,
  input  logic [DW-1:0] imm,
  output logic [DW-1:0] y
);

  always_comb begin
    case (op)
      OP_ADD:  y = a + b;
      OP_SUB:  y = a - b;
      OP_AND:  y = a & b;
      OP_OR:   y = a | b;
      OP_XOR:  y = a ^ b;
      OP_PASA: y = a;
      OP_IMM:  y = imm;
      default: y = '0;
    endcase
  end

endmodule

// File: rtl/tribus_regfile.sv
module tribus_regfile #(
  parameter  int DW   = 16,
  parameter  int NREG = 4,
  localparam int RW   = $clog2(NREG)
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic [RW-1:0] sel_a,
  input  logic [RW-1:0] sel_b,
  output logic [DW-1:0] rd_a,
  output logic [DW-1:0] rd_b,
  input  logic          we,
  input  logic [RW-1:0] wsel,
  input  logic [DW-1:0] wdata
);

  logic [DW-1:0] q [NREG];

  for (genvar g = 0; g < NREG; g++) begin : g_reg
    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
        q[g] <= '0;
      end else if (we && (wsel == RW'(g))) begin
        q[g] <= wdata;
      end
    end
  end

  // Two independent read ports: A and B may name the same register
  assign rd_a = q[sel_a];
  assign rd_b = q[sel_b];

endmodule

// File: rtl/tribus_mem.sv
module tribus_mem #(
  parameter  int DW    = 16,
  parameter  int WORDS = 32,
  localparam int AW    = $clog2(WORDS)
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic [AW-1:0] addr,
  output logic [DW-1:0] rdata,
  input  logic          we,
  input  logic [DW-1:0] wdata
);

  logic [DW-1:0] word [WORDS];

  for (genvar g = 0; g < WORDS; g++) begin : g_word
    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
        word[g] <= '0;
      end else if (we && (addr == AW'(g))) begin
        word[g] <= wdata;
      end
    end
  end

  assign rdata = word[addr];

endmodule

// File: rtl/tribus_datapath.sv
module tribus_datapath
  import tribus_pkg::*;
#(
  parameter  int DW        = 16,
  parameter  int NREG      = 4,
  parameter  int MEM_WORDS = 32,
  parameter  int MEM_LAT   = 3,
  localparam int RW        = $clog2(NREG),
  localparam int AW        = $clog2(MEM_WORDS),
  localparam int LW        = $clog2(MEM_LAT + 1) + 1
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          cw_valid,
  output logic          cw_ready,
  input  logic [RW-1:0] cw_a_sel,
  input  logic [RW-1:0] cw_b_sel,
  input  logic [2:0]    cw_op,
  input  logic [DW-1:0] cw_imm,
  input  logic [RW-1:0] cw_c_sel,
  input  logic [AW-1:0] cw_addr,
  input  logic          cw_mem_wr,
  input  logic          cw_c_en,
  input  logic          cw_m_en,
  output logic          busy,
  output logic          done,
  output logic [DW-1:0] res_data
);

  dp_state_e     state;
  logic [LW-1:0] wait_cnt;

  // Control word held for the duration of the cycle
  logic [RW-1:0] l_a, l_b, l_c;
  logic [2:0]    l_op;
  logic [DW-1:0] l_imm;
  logic [AW-1:0] l_addr;
  logic          l_wr, l_cen, l_men;

  logic          accept, commit;
  logic [DW-1:0] a_bus, b_bus, alu_y, mem_q, c_value;
  logic          rf_we, mem_we;

  assign cw_ready = (state == ST_IDLE);
  assign busy     = (state == ST_EXEC);
  assign accept   = cw_valid && cw_ready;
  assign commit   = busy && (wait_cnt == '0);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      state    <= ST_IDLE;
      wait_cnt <= '0;
      l_a      <= '0;
      l_b      <= '0;
      l_c      <= '0;
      l_op     <= '0;
      l_imm    <= '0;
      l_addr   <= '0;
      l_wr     <= 1'b0;
      l_cen    <= 1'b0;
      l_men    <= 1'b0;
    end else if (accept) begin
      state    <= ST_EXEC;
      wait_cnt <= cw_m_en ? LW'(MEM_LAT) : '0;
      l_a      <= cw_a_sel;
      l_b      <= cw_b_sel;
      l_c      <= cw_c_sel;
      l_op     <= cw_op;
      l_imm    <= cw_imm;
      l_addr   <= cw_addr;
      l_wr     <= cw_mem_wr;
      l_cen    <= cw_c_en;
      l_men    <= cw_m_en;
    end else if (commit) begin
      state <= ST_IDLE;
    end else if (busy) begin
      wait_cnt <= wait_cnt - 1'b1;
    end
  end

  // Step 1: registers onto A and B buses
  tribus_regfile #(.DW(DW), .NREG(NREG)) u_rf (
    .clk   (clk),
    .rst_n (rst_n),
    .sel_a (l_a),
    .sel_b (l_b),
    .rd_a  (a_bus),
    .rd_b  (b_bus),
    .we    (rf_we),
    .wsel  (l_c),
    .wdata (c_value)
  );

  // Step 2: ALU produces the C value
  tribus_alu #(.DW(DW)) u_alu (
    .op  (l_op),
    .a   (a_bus),
    .b   (b_bus),
    .imm (l_imm),
    .y   (alu_y)
  );

  tribus_mem #(.DW(DW), .WORDS(MEM_WORDS)) u_mem (
    .clk   (clk),
    .rst_n (rst_n),
    .addr  (l_addr),
    .rdata (mem_q),
    .we    (mem_we),
    .wdata (alu_y)
  );

  // Step 3: route C through whichever buses are closed
  assign c_value = (l_men && !l_wr) ? mem_q : alu_y;
  assign rf_we   = commit && l_cen && !(l_men && l_wr);
  assign mem_we  = commit && l_cen && l_men && l_wr;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      done     <= 1'b0;
      res_data <= '0;
    end else begin
      done <= commit;
      if (commit) begin
        res_data <= c_value;
      end
    end
  end

endmodule

// File: rtl/tribus_chk.sv
module tribus_chk #(
  parameter int DW      = 16,
  parameter int MEM_LAT = 3
) (
  input logic          clk,
  input logic          rst_n,
  input logic          cw_valid,
  input logic          cw_ready,
  input logic          cw_m_en,
  input logic          busy,
  input logic          done,
  input logic [DW-1:0] res_data,
  input logic          rf_we,
  input logic          mem_we,
  input logic          l_cen
);

  logic [15:0] lat_cnt;
  logic        lat_mem;
  logic        acc;

  assign acc = cw_valid && cw_ready;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      lat_cnt <= '0;
      lat_mem <= 1'b0;
    end else if (acc) begin
      lat_cnt <= '0;
      lat_mem <= cw_m_en;
    end else if (busy) begin
      lat_cnt <= lat_cnt + 16'd1;
    end
  end

  p_accept_busy_r1: assert property (@(posedge clk) disable iff (!rst_n)
    acc |=> (busy && !cw_ready));

  p_reg_latency_r2: assert property (@(posedge clk) disable iff (!rst_n)
    (acc && !cw_m_en) |-> ##2 done);

  p_latency_cnt_r2: assert property (@(posedge clk) disable iff (!rst_n)
    done |-> (lat_cnt == (lat_mem ? 16'(MEM_LAT + 1) : 16'd1)));

  p_done_pulse_r2: assert property (@(posedge clk) disable iff (!rst_n)
    done |=> !done);

  p_open_c_no_reg_r6: assert property (@(posedge clk) disable iff (!rst_n)
    rf_we |-> l_cen);

  p_open_c_no_mem_r6: assert property (@(posedge clk) disable iff (!rst_n)
    mem_we |-> l_cen);

  p_write_excl_r7: assert property (@(posedge clk) disable iff (!rst_n)
    !(rf_we && mem_we));

  p_res_hold_r10: assert property (@(posedge clk) disable iff (!rst_n)
    !done |-> $stable(res_data));

endmodule

bind tribus_datapath tribus_chk #(.DW(DW), .MEM_LAT(MEM_LAT)) u_chk (
  .clk      (clk),
  .rst_n    (rst_n),
  .cw_valid (cw_valid),
  .cw_ready (cw_ready),
  .cw_m_en  (cw_m_en),
  .busy     (busy),
  .done     (done),
  .res_data (res_data),
  .rf_we    (rf_we),
  .mem_we   (mem_we),
  .l_cen    (l_cen)
);

// File: tb/tribus_datapath_tb.sv
`timescale 1ns/1ps
module tribus_datapath_tb;

  localparam int LAT = 3;

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        cw_valid = 1'b0;
  logic        cw_ready;
  logic [1:0]  cw_a_sel = '0, cw_b_sel = '0, cw_c_sel = '0;
  logic [2:0]  cw_op = '0;
  logic [15:0] cw_imm = '0;
  logic [4:0]  cw_addr = '0;
  logic        cw_mem_wr = 1'b0, cw_c_en = 1'b0, cw_m_en = 1'b0;
  logic        busy, done;
  logic [15:0] res_data;

  int n_chk = 0;
  int n_fail = 0;
  logic [15:0] regs_m [4];
  logic [15:0] mem_m  [32];

  always #4 clk = ~clk;

  tribus_datapath #(.MEM_LAT(LAT)) u_dut (
    .clk(clk), .rst_n(rst_n), .cw_valid(cw_valid), .cw_ready(cw_ready),
    .cw_a_sel(cw_a_sel), .cw_b_sel(cw_b_sel), .cw_op(cw_op), .cw_imm(cw_imm),
    .cw_c_sel(cw_c_sel), .cw_addr(cw_addr), .cw_mem_wr(cw_mem_wr),
    .cw_c_en(cw_c_en), .cw_m_en(cw_m_en), .busy(busy), .done(done),
    .res_data(res_data)
  );

  function automatic logic [15:0] alu_f(input logic [2:0] op,
                                        input logic [15:0] a, b, imm);
    case (op)
      3'b000: return a + b;
      3'b001: return a - b;
      3'b010: return a & b;
      3'b011: return a | b;
      3'b100: return a ^ b;
      3'b101: return a;
      3'b110: return imm;
      default: return 16'h0000;
    endcase
  endfunction

  task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s: actual %0h expected %0h", req, act, exp);
    end
  endtask

  task automatic do_op(input logic [1:0] a, b, input logic [2:0] op,
                       input logic [1:0] c, input logic [4:0] ad,
                       input logic wr, cen, men, input logic [15:0] imm,
                       input string tag);
    logic [15:0] alu, exp;
    int n;
    alu = alu_f(op, regs_m[a], regs_m[b], imm);
    exp = (men && !wr) ? mem_m[ad] : alu;
    chk("R1 ready when idle", cw_ready, 1);
    cw_a_sel = a; cw_b_sel = b; cw_op = op; cw_c_sel = c; cw_addr = ad;
    cw_mem_wr = wr; cw_c_en = cen; cw_m_en = men; cw_imm = imm;
    cw_valid = 1'b1;
    @(posedge clk);
    @(negedge clk);
    cw_valid = 1'b0;
    chk("R1 busy after accept", {busy, cw_ready}, 2'b10);
    n = 0;
    while (!done && n < 40) begin
      @(posedge clk);
      @(negedge clk);
      n++;
    end
    chk("R2 latency", n, men ? 1 + LAT : 1);
    chk(tag, res_data, exp);
    if (cen) begin
      if (men && wr) mem_m[ad] = alu;
      else if (men) regs_m[c] = mem_m[ad];
      else regs_m[c] = alu;
    end
    @(negedge clk);
    chk("R2 done single pulse", done, 0);
  endtask

  task automatic peek_reg(input logic [1:0] r, input string tag);
    do_op(r, 2'd0, 3'b101, 2'd0, 5'd0, 1'b0, 1'b0, 1'b0, 16'h0, tag);
  endtask

  task automatic peek_mem(input logic [4:0] ad, input string tag);
    do_op(2'd0, 2'd0, 3'b000, 2'd0, ad, 1'b0, 1'b0, 1'b1, 16'h0, tag);
  endtask

  initial begin
    repeat (100000) @(posedge clk);
    n_fail++;
    $display("FAIL watchdog: actual hung expected finish");
    $display("%0d/%0d checks passed", n_chk + 1 - n_fail, n_chk + 1);
    $finish;
  end

  initial begin
    for (int i = 0; i < 4; i++) regs_m[i] = '0;
    for (int i = 0; i < 32; i++) mem_m[i] = '0;
    void'($urandom(32'd20240611));
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    // R9: reset state
    chk("R9 reset outputs", {busy, done, cw_ready}, 3'b001);
    chk("R9 reset res_data", res_data, 0);
    for (int i = 0; i < 4; i++) peek_reg(2'(i), "R9 register zero");
    peek_mem(5'd0, "R9 memory zero");
    peek_mem(5'd31, "R9 memory zero");

    // R3 immediate, R5 register destination
    do_op(2'd0, 2'd0, 3'b110, 2'd0, 5'd0, 1'b0, 1'b1, 1'b0, 16'h1234, "R3 imm");
    do_op(2'd0, 2'd0, 3'b110, 2'd1, 5'd0, 1'b0, 1'b1, 1'b0, 16'hF00F, "R3 imm");
    do_op(2'd0, 2'd1, 3'b000, 2'd2, 5'd0, 1'b0, 1'b1, 1'b0, 16'h0, "R5 add to R2");
    peek_reg(2'd2, "R5 readback");
    do_op(2'd0, 2'd1, 3'b001, 2'd3, 5'd0, 1'b0, 1'b1, 1'b0, 16'h0, "R3 subtract wrap");
    do_op(2'd1, 2'd1, 3'b100, 2'd3, 5'd0, 1'b0, 1'b1, 1'b0, 16'h0, "R4 same register xor");
    do_op(2'd1, 2'd1, 3'b000, 2'd3, 5'd0, 1'b0, 1'b1, 1'b0, 16'h0, "R4 same register add");
    do_op(2'd0, 2'd1, 3'b111, 2'd0, 5'd0, 1'b0, 1'b0, 1'b0, 16'hFFFF, "R3 code 111 zero");
    // R6: C bus open, nothing changes
    do_op(2'd0, 2'd1, 3'b000, 2'd1, 5'd7, 1'b1, 1'b0, 1'b1, 16'h0, "R6 open C mem write");
    do_op(2'd0, 2'd1, 3'b110, 2'd1, 5'd7, 1'b0, 1'b0, 1'b0, 16'hBEEF, "R6 open C reg");
    peek_reg(2'd1, "R6 register kept");
    peek_mem(5'd7, "R6 memory kept");
    // R7: direct ALU to memory at boundaries
    do_op(2'd0, 2'd1, 3'b000, 2'd0, 5'd31, 1'b1, 1'b1, 1'b1, 16'h0, "R7 write addr 31");
    do_op(2'd1, 2'd0, 3'b001, 2'd0, 5'd0, 1'b1, 1'b1, 1'b1, 16'h0, "R7 write addr 0");
    peek_reg(2'd0, "R7 register kept");
    peek_mem(5'd31, "R7 memory 31");
    // R8: memory to register
    do_op(2'd0, 2'd0, 3'b000, 2'd3, 5'd31, 1'b0, 1'b1, 1'b1, 16'h0, "R8 load addr 31");
    do_op(2'd0, 2'd0, 3'b000, 2'd2, 5'd0, 1'b0, 1'b1, 1'b1, 16'h0, "R8 load addr 0");
    peek_reg(2'd3, "R8 readback");
    peek_reg(2'd2, "R8 readback");

    // Constrained random mix
    for (int k = 0; k < 300; k++) begin
      logic cen, men, wr;
      string tag;
      cen = ($urandom % 4) != 0;
      men = $urandom % 2;
      wr  = $urandom % 2;
      if (!cen) tag = "R6 random";
      else if (men && wr) tag = "R7 random";
      else if (men) tag = "R8 random";
      else tag = "R5 random";
      do_op(2'($urandom), 2'($urandom), 3'($urandom), 2'($urandom),
            5'($urandom), wr, cen, men, 16'($urandom), tag);
    end
    for (int i = 0; i < 4; i++) peek_reg(2'(i), "R10 final register");
    for (int i = 0; i < 32; i++) peek_mem(5'(i), "R10 final memory");

    $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
    $finish;
  end

endmodule